// File: doc/BRIEF.md
# Host Pipe Two-Bank Flow and CRC Error Tracker

This block watches one host-side USB pipe that moves data through ping-pong banks. It is told the pipe's transfer type and direction, which banks currently hold data, and which bank is current. It also receives strobes for an attempted OUT stage, an arriving IN packet, a completed transaction and a failed CRC check. From these it records overflow and underflow per bank, and it raises a flow-error flag and a CRC-error flag. Each flag has an enable, and the enabled flags together drive one pipe interrupt.

The tracker also keeps the current bank pointer and the data toggle bit. Both advance as transactions complete. When software moves the pipe to another logical pipe, it can restore a saved bank number and toggle value through dedicated load strobes. Software clears each flag with a write-one strobe. A per-bank status bit then clears itself on the first successful transaction that follows.

Top module: `usb_pipe_err_tracker`

## Requirements
- R1: `pipeType` is coded 0 = control, 1 = isochronous, 2 = bulk, 3 = interrupt. Overflow and underflow are recorded only for codes 1 and 3. Control and bulk pipes never change `ovfStat`, `unfStat` or `flowFlag`.
- R2: When `outStage` is high on an OUT pipe (`dirIn`=0) and the current bank is empty (`bankFull[curBank]`=0), `ovfStat[curBank]` and `flowFlag` are set at the next edge.
- R3: When `inPacket` is high on an IN pipe (`dirIn`=1) and the current bank is already full, `unfStat[curBank]` and `flowFlag` are set at the next edge. The bank pointer and toggle are left unchanged.
- R4: `pipeIrq` is high because of a flow error only while both `flowFlag` and the flow enable are 1.
- R5: A pulse on `txnOk` clears every `ovfStat` and `unfStat` bit only when `flowFlag` was already 0 at that edge. While the flag is set, the status bits hold.
- R6: `crcFail` sets `crcFlag` only on an isochronous IN pipe. For any other type or direction it has no effect.
- R7: Each `txnOk` pulse moves `curBank` to the next bank: 0 to 1, and 1 back to 0.
- R8: `dataTgl` inverts on each `txnOk` pulse unless the pipe is isochronous, in which case it holds.
- R9: `initBank` loads `initBankVal` into `curBank`, and `initTgl` loads `initTglVal` into `dataTgl`. Each load takes priority over the advance caused by `txnOk` in the same cycle.
- R10: A pulse on `flowClr` or `crcClr` clears the matching flag. If a new error of that kind arrives in the same cycle, the flag is set instead.
- R11: `pipeIrq` = (`flowFlag` AND flow enable) OR (`crcFlag` AND CRC enable). Both enables are loaded together from `cfgFlowEn` and `cfgCrcEn` when `cfgWr` is high.
- R12: A synchronous reset (`rstN`=0) clears both flags, all status bits and both enables, and sets `curBank` and `dataTgl` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| pipeType | input | 2 | Transfer type code (see R1) |
| dirIn | input | 1 | 1 = IN pipe, 0 = OUT pipe |
| bankFull | input | NUM_BANKS | Per-bank full status, 1 = full |
| outStage | input | 1 | Strobe: OUT stage attempted from current bank |
| inPacket | input | 1 | Strobe: IN packet arrived for current bank |
| txnOk | input | 1 | Strobe: transaction completed successfully |
| crcFail | input | 1 | Strobe: received packet failed its CRC |
| flowClr | input | 1 | Write-one clear of the flow-error flag |
| crcClr | input | 1 | Write-one clear of the CRC-error flag |
| cfgWr | input | 1 | Loads both interrupt enables |
| cfgFlowEn | input | 1 | Flow-error enable value |
| cfgCrcEn | input | 1 | CRC-error enable value |
| initBank | input | 1 | Loads the bank pointer |
| initBankVal | input | BANK_W | Bank number to load |
| initTgl | input | 1 | Loads the data toggle |
| initTglVal | input | 1 | Toggle value to load |
| curBank | output | BANK_W | Current bank pointer |
| dataTgl | output | 1 | Current data toggle |
| ovfStat | output | NUM_BANKS | Per-bank overflow status |
| unfStat | output | NUM_BANKS | Per-bank underflow status |
| flowFlag | output | 1 | Flow-error interrupt flag |
| crcFlag | output | 1 | CRC-error interrupt flag |
| pipeIrq | output | 1 | Combined pipe interrupt |

## Verification
Two kinds of event can fall into the same cycle. One is a software clear of a flag together with a new error of that kind. The other is a context-restore load together with the bank advance from a completed transaction. The bench applies `flowClr` in the same cycle as an empty-bank OUT stage, and `crcClr` in the same cycle as an isochronous IN CRC failure. It then expects both flags to read 1 one cycle later. It also pulses `initBank` and `initTgl` together with `txnOk` and expects the loaded values, not the advanced ones, while the status bits stay put because the flow flag is still set.

// File: rtl/pipe_err_pkg.sv
package pipe_err_pkg;

  typedef enum logic [1:0] {
    PK_CTRL = 2'd0,
    PK_ISO  = 2'd1,
    PK_BULK = 2'd2,
    PK_INTR = 2'd3
  } pipeKind_e;

  // strobes from the event decoder to the state holder
  typedef struct packed {
    logic setOvf;
    logic setUnf;
    logic setCrc;
    logic advance;
    logic flipTgl;
  } errStrobe_t;

endpackage

// File: rtl/pipe_err_ctrl.sv
module pipe_err_ctrl
  import pipe_err_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic [1:0]           pipeType,
  input  logic                 dirIn,
  input  logic [NUM_BANKS-1:0] bankFull,
  input  logic                 outStage,
  input  logic                 inPacket,
  input  logic                 txnOk,
  input  logic                 crcFail,
  input  logic [BANK_W-1:0]    curBank,
  output errStrobe_t           strobe
);

  pipeKind_e kind;
  logic      curFull;
  logic      flowKind;

  always_comb begin
    kind     = pipeKind_e'(pipeType);
    curFull  = bankFull[curBank];
    flowKind = (kind == PK_ISO) || (kind == PK_INTR);

    strobe.setOvf  = flowKind && !dirIn && outStage && !curFull;
    strobe.setUnf  = flowKind && dirIn && inPacket && curFull;
    strobe.setCrc  = (kind == PK_ISO) && dirIn && crcFail;
    strobe.advance = txnOk;
    strobe.flipTgl = txnOk && (kind != PK_ISO);
  end

endmodule

// File: rtl/pipe_err_dp.sv
module pipe_err_dp
  import pipe_err_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  errStrobe_t           strobe,
  input  logic                 flowClr,
  input  logic                 crcClr,
  input  logic                 cfgWr,
  input  logic                 cfgFlowEn,
  input  logic                 cfgCrcEn,
  input  logic                 initBank,
  input  logic [BANK_W-1:0]    initBankVal,
  input  logic                 initTgl,
  input  logic                 initTglVal,
  output logic [BANK_W-1:0]    curBank,
  output logic                 dataTgl,
  output logic [NUM_BANKS-1:0] ovfStat,
  output logic [NUM_BANKS-1:0] unfStat,
  output logic                 flowFlag,
  output logic                 crcFlag,
  output logic                 flowEn,
  output logic                 crcEn
);

  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic              statClr;
  logic              setFlow;
  logic [BANK_W-1:0] nextBank;

  assign statClr  = strobe.advance && !flowFlag;
  assign setFlow  = strobe.setOvf || strobe.setUnf;
  assign nextBank = (curBank == LAST_BANK) ? '0 : curBank + BANK_W'(1);

  // per-bank status bits
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ovfStat[b] <= 1'b0;
        unfStat[b] <= 1'b0;
      end else begin
        if (strobe.setOvf && curBank == BANK_W'(b)) ovfStat[b] <= 1'b1;
        else if (statClr)                           ovfStat[b] <= 1'b0;
        if (strobe.setUnf && curBank == BANK_W'(b)) unfStat[b] <= 1'b1;
        else if (statClr)                           unfStat[b] <= 1'b0;
      end
    end

    // R2
    ovf_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $rose(ovfStat[b])) |-> $past(strobe.setOvf && curBank == BANK_W'(b)));
    // R3
    unf_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $rose(unfStat[b])) |-> $past(strobe.setUnf && curBank == BANK_W'(b)));
    // R5
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && ($fell(ovfStat[b]) || $fell(unfStat[b])))
        |-> $past(strobe.advance && !flowFlag));
  end

  // flags: a new error wins over a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flowFlag <= 1'b0;
      crcFlag  <= 1'b0;
    end else begin
      if (setFlow)      flowFlag <= 1'b1;
      else if (flowClr) flowFlag <= 1'b0;
      if (strobe.setCrc) crcFlag <= 1'b1;
      else if (crcClr)   crcFlag <= 1'b0;
    end
  end

  // R10
  flow_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    setFlow |=> flowFlag);

  // enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flowEn <= 1'b0;
      crcEn  <= 1'b0;
    end else if (cfgWr) begin
      flowEn <= cfgFlowEn;
      crcEn  <= cfgCrcEn;
    end
  end

  // bank pointer and toggle; loads win over advance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBank <= '0;
      dataTgl <= 1'b0;
    end else begin
      if (initBank)            curBank <= initBankVal;
      else if (strobe.advance) curBank <= nextBank;
      if (initTgl)             dataTgl <= initTglVal;
      else if (strobe.flipTgl) dataTgl <= ~dataTgl;
    end
  end

endmodule

// File: rtl/usb_pipe_err_tracker.sv
module usb_pipe_err_tracker
  import pipe_err_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           pipeType,
  input  logic                 dirIn,
  input  logic [NUM_BANKS-1:0] bankFull,
  input  logic                 outStage,
  input  logic                 inPacket,
  input  logic                 txnOk,
  input  logic                 crcFail,
  input  logic                 flowClr,
  input  logic                 crcClr,
  input  logic                 cfgWr,
  input  logic                 cfgFlowEn,
  input  logic                 cfgCrcEn,
  input  logic                 initBank,
  input  logic [BANK_W-1:0]    initBankVal,
  input  logic                 initTgl,
  input  logic                 initTglVal,
  output logic [BANK_W-1:0]    curBank,
  output logic                 dataTgl,
  output logic [NUM_BANKS-1:0] ovfStat,
  output logic [NUM_BANKS-1:0] unfStat,
  output logic                 flowFlag,
  output logic                 crcFlag,
  output logic                 pipeIrq
);

  errStrobe_t strobe;
  logic       flowEn;
  logic       crcEn;

  pipe_err_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) uCtrl (
    .pipeType (pipeType),
    .dirIn    (dirIn),
    .bankFull (bankFull),
    .outStage (outStage),
    .inPacket (inPacket),
    .txnOk    (txnOk),
    .crcFail  (crcFail),
    .curBank  (curBank),
    .strobe   (strobe)
  );

  pipe_err_dp #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .flowClr     (flowClr),
    .crcClr      (crcClr),
    .cfgWr       (cfgWr),
    .cfgFlowEn   (cfgFlowEn),
    .cfgCrcEn    (cfgCrcEn),
    .initBank    (initBank),
    .initBankVal (initBankVal),
    .initTgl     (initTgl),
    .initTglVal  (initTglVal),
    .curBank     (curBank),
    .dataTgl     (dataTgl),
    .ovfStat     (ovfStat),
    .unfStat     (unfStat),
    .flowFlag    (flowFlag),
    .crcFlag     (crcFlag),
    .flowEn      (flowEn),
    .crcEn       (crcEn)
  );

  // R11
  assign pipeIrq = (flowFlag && flowEn) || (crcFlag && crcEn);

  // R6
  crc_only_iso_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(crcFlag)) |-> $past(crcFail && dirIn && pipeType == 2'd1));
  // R1
  flow_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(flowFlag)) |-> $past(pipeType == 2'd1 || pipeType == 2'd3));
  // R7
  bank_alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && txnOk && !initBank) |-> (curBank != $past(curBank)));
  // R8
  iso_tgl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && txnOk && !initTgl && pipeType == 2'd1) |-> $stable(dataTgl));

endmodule

// File: tb/usb_pipe_err_tracker_test.sv
`timescale 1ns/1ps
module usb_pipe_err_tracker_test;

  typedef struct packed {
    logic [3:0] tag;
    logic [1:0] typ;
    logic       din;
    logic [1:0] full;
    logic       outS;
    logic       inP;
    logic       ok;
    logic       crc;
    logic       fClr;
    logic       cClr;
    logic [8:0] exp;   // {bank,tgl,ovf[1:0],unf[1:0],flowFlag,crcFlag,irq}
  } vec_t;

  // types: 0 ctrl, 1 iso, 2 bulk, 3 intr
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  2'd3, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'b0_0_01_00_1_0_1}, // R2 overflow bank0
    '{4'd5,  2'd3, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'b1_1_01_00_1_0_1}, // R5 hold while flag set
    '{4'd10, 2'd3, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'b1_1_01_00_0_0_0}, // R10 clear flow flag
    '{4'd5,  2'd3, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'b0_0_00_00_0_0_0}, // R5 status clears
    '{4'd1,  2'd2, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'b0_0_00_00_0_0_0}, // R1 bulk no overflow
    '{4'd3,  2'd1, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'b0_0_00_01_1_0_1}, // R3 underflow bank0
    '{4'd8,  2'd1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'b1_0_00_01_1_0_1}, // R8 iso toggle holds
    '{4'd3,  2'd1, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'b1_0_00_11_1_0_1}, // R3 underflow bank1
    '{4'd6,  2'd1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'b1_0_00_11_1_1_1}, // R6 iso IN crc
    '{4'd10, 2'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'b1_0_00_11_0_0_0}, // R10 both clears
    '{4'd6,  2'd3, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'b1_0_00_11_0_0_0}, // R6 intr crc ignored
    '{4'd6,  2'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'b1_0_00_11_0_0_0}, // R6 iso OUT crc ignored
    '{4'd7,  2'd2, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'b0_1_00_00_0_0_0}, // R7 wrap, bulk flips
    '{4'd3,  2'd3, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'b0_1_00_00_0_0_0}, // R3 empty bank no underflow
    '{4'd1,  2'd0, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'b0_1_00_00_0_0_0}, // R1 control no underflow
    '{4'd2,  2'd3, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'b0_1_00_00_0_0_0}  // R2 full bank no overflow
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] pipeType;
  logic       dirIn;
  logic [1:0] bankFull;
  logic       outStage, inPacket, txnOk, crcFail, flowClr, crcClr;
  logic       cfgWr, cfgFlowEn, cfgCrcEn;
  logic       initBank, initBankVal, initTgl, initTglVal;
  logic       curBank, dataTgl;
  logic [1:0] ovfStat, unfStat;
  logic       flowFlag, crcFlag, pipeIrq;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  usb_pipe_err_tracker uut (
    .clk(clk), .rstN(rstN), .pipeType(pipeType), .dirIn(dirIn), .bankFull(bankFull),
    .outStage(outStage), .inPacket(inPacket), .txnOk(txnOk), .crcFail(crcFail),
    .flowClr(flowClr), .crcClr(crcClr), .cfgWr(cfgWr), .cfgFlowEn(cfgFlowEn),
    .cfgCrcEn(cfgCrcEn), .initBank(initBank), .initBankVal(initBankVal),
    .initTgl(initTgl), .initTglVal(initTglVal), .curBank(curBank), .dataTgl(dataTgl),
    .ovfStat(ovfStat), .unfStat(unfStat), .flowFlag(flowFlag), .crcFlag(crcFlag),
    .pipeIrq(pipeIrq)
  );

  function automatic logic [8:0] snap();
    return {curBank, dataTgl, ovfStat, unfStat, flowFlag, crcFlag, pipeIrq};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    pipeType = 2'd0; dirIn = 1'b0; bankFull = 2'b00;
    outStage = 1'b0; inPacket = 1'b0; txnOk = 1'b0; crcFail = 1'b0;
    flowClr = 1'b0; crcClr = 1'b0; cfgWr = 1'b0; cfgFlowEn = 1'b0; cfgCrcEn = 1'b0;
    initBank = 1'b0; initBankVal = 1'b0; initTgl = 1'b0; initTglVal = 1'b0;
  endtask

  // inputs are already driven at a negedge; clock one edge and sample at the next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    idle();
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    idle();
    doReset();
    // R12 reset state
    check("R12", snap(), 9'b0);

    // enable both interrupts (R11)
    cfgWr = 1'b1; cfgFlowEn = 1'b1; cfgCrcEn = 1'b1;
    tick();
    idle();

    for (int i = 0; i < NV; i++) begin
      pipeType = VECS[i].typ; dirIn = VECS[i].din; bankFull = VECS[i].full;
      outStage = VECS[i].outS; inPacket = VECS[i].inP; txnOk = VECS[i].ok;
      crcFail = VECS[i].crc; flowClr = VECS[i].fClr; crcClr = VECS[i].cClr;
      tick();
      idle();
      check($sformatf("R%0d vec%0d", VECS[i].tag, i), snap(), VECS[i].exp);
    end
    // state now: bank0, tgl1, no status, no flags

    // R10 overflow and flow clear in the same cycle: set wins
    pipeType = 2'd1; dirIn = 1'b0; bankFull = 2'b00; outStage = 1'b1; flowClr = 1'b1;
    tick(); idle();
    check("R10 flow set over clear", snap(), 9'b0_1_01_00_1_0_1);

    // R10 CRC error and CRC clear in the same cycle: set wins
    pipeType = 2'd1; dirIn = 1'b1; crcFail = 1'b1; crcClr = 1'b1;
    tick(); idle();
    check("R10 crc set over clear", snap(), 9'b0_1_01_00_1_1_1);

    // R4 flow enable off, CRC keeps irq high
    cfgWr = 1'b1; cfgFlowEn = 1'b0; cfgCrcEn = 1'b1;
    tick(); idle();
    check("R11 crc alone drives irq", snap(), 9'b0_1_01_00_1_1_1);
    crcClr = 1'b1;
    tick(); idle();
    check("R4 flow flag masked", snap(), 9'b0_1_01_00_1_0_0);

    // R9 loads beat the advance; R5 status held since flow flag still set
    pipeType = 2'd3; txnOk = 1'b1;
    initBank = 1'b1; initBankVal = 1'b0; initTgl = 1'b1; initTglVal = 1'b1;
    tick(); idle();
    check("R9 load over advance", snap(), 9'b0_1_01_00_1_0_0);
    initBank = 1'b1; initBankVal = 1'b1; initTgl = 1'b1; initTglVal = 1'b0;
    tick(); idle();
    check("R9 load values", snap(), 9'b1_0_01_00_1_0_0);

    // R12 reset mid-run clears everything, including enables
    doReset();
    check("R12 mid-run reset", snap(), 9'b0);
    pipeType = 2'd3; dirIn = 1'b0; bankFull = 2'b00; outStage = 1'b1;
    tick(); idle();
    check("R12 enables cleared", snap(), 9'b0_0_01_00_1_0_0);
    cfgWr = 1'b1; cfgFlowEn = 1'b1; cfgCrcEn = 1'b0;
    tick(); idle();
    check("R4 flow enable asserts irq", snap(), 9'b0_0_01_00_1_0_1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule